// File: doc/BRIEF.md
# Serial Configuration Register Bank

This block is the write-only setup port of a mixed-signal front end. A host drives three wires (an active-low select, a serial clock and a data line) and sends 16-bit frames. The block brings the three wires into its own clock domain and collects the bits of each frame. The three top bits of a frame pick a register; the thirteen bits below them are the payload. The payload goes into the chosen register only when the select line is released, and only if exactly sixteen clock edges arrived while it was low.

Four user registers carry the parallel control fields:
- an amplifier gain code and two input-source selects;
- power-down modes, output-mode bits and two filter selects;
- a clamp level, fast-settling controls, a low-power flag, two polarity inversions and an active-low soft reset;
- an auxiliary word.

Register numbers four to seven are kept for test and cannot be written. While the soft-reset bit is low, the other three user registers are held at their defaults.

Top module: `ser_cfg_bank`

## Requirements
- R1: After the asynchronous reset `rst_n` is released, every field shows its default value. Gain is 0x040, clamp level is 0x10 and `soft_rst_n` is 1. All other fields are 0.
- R2: Bits are shifted in least significant bit first. Frame bits 15:13 hold the register number and bits 12:0 hold the payload.
- R3: A register changes only after the select line rises. Until the select line rises, a complete frame that is still held low leaves every output unchanged.
- R4: A frame with fewer than 16 serial clock rising edges is discarded and changes nothing.
- R5: A frame with more than 16 serial clock rising edges is discarded and changes nothing.
- R6: Frames addressed to registers 4 to 7 change no output.
- R7: In register 0, payload bits 9:0 are `gain_code`, bit 10 is `in_sel_a` and bit 11 is `in_sel_b`.
- R8: In register 1, the payload fields are:
  - bit 0 is `sleep_en`;
  - bit 1 is `stby_en`;
  - bits 4:2 are `out_mode`;
  - bits 6:5 are `sh_filt`;
  - bits 10:7 are `sw_filt`.
- R9: In register 2, the payload fields are:
  - bits 4:0 are `clamp_lvl`;
  - bits 6:5 are `fast_mult`;
  - bits 8:7 are `fast_time`;
  - bit 9 is `low_pwr`;
  - bit 10 is `pol_inv_a`;
  - bit 11 is `pol_inv_b`;
  - bit 12 is `soft_rst_n`.
- R10: While `soft_rst_n` is 0, registers 0, 1 and 3 return to their defaults and ignore writes. Register 2 stays writable.
- R11: Register 3 payload bits 12:0 appear unchanged on `aux_cfg`.
- R12: Serial clock edges that occur while the select line is high are not counted toward the next frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ser_sel_n | input | 1 | Serial select, active low |
| ser_clk | input | 1 | Serial clock, sampled on rising edge |
| ser_dat | input | 1 | Serial data |
| gain_code | output | 10 | Amplifier gain code |
| in_sel_a | output | 1 | Input source select A |
| in_sel_b | output | 1 | Input source select B |
| sleep_en | output | 1 | Sleep request |
| stby_en | output | 1 | Standby request |
| out_mode | output | 3 | Output-mode bits |
| sh_filt | output | 2 | Sample-and-hold filter select |
| sw_filt | output | 4 | Switch filter select |
| clamp_lvl | output | 5 | Clamp level |
| fast_mult | output | 2 | Fast-settling gain multiplier |
| fast_time | output | 2 | Fast-settling cancel time |
| low_pwr | output | 1 | Low-power flag |
| pol_inv_a | output | 1 | Polarity inversion A |
| pol_inv_b | output | 1 | Polarity inversion B |
| soft_rst_n | output | 1 | Soft reset, active low |
| aux_cfg | output | 13 | Auxiliary configuration word |

## Verification
Two things can land on the same register edge: a frame commit to register 0, 1 or 3, and the forced reload from a low soft-reset bit. To provoke this, the bench first writes register 2 with bit 12 clear. It then sends a full, valid frame to register 0 while the soft reset is still low, and expects the default to win. It then releases the soft reset and checks that the next write lands. A checker property also requires the defaults on every cycle that follows a low soft-reset bit, whether or not a commit happened in the same cycle.

// File: rtl/ser_cfg_pkg.sv
package ser_cfg_pkg;
   localparam int unsigned USER_REGS   = 4;
   localparam int unsigned MAP_BITS    = 13;
   localparam int unsigned REG_GAIN    = 0;
   localparam int unsigned REG_MODE    = 1;
   localparam int unsigned REG_ANALOG  = 2;
   localparam int unsigned REG_AUX     = 3;
   localparam int unsigned SRST_BIT    = 12;

   localparam int unsigned GAIN_LSB    = 0;
   localparam int unsigned GAIN_W      = 10;
   localparam int unsigned SELA_BIT    = 10;
   localparam int unsigned SELB_BIT    = 11;

   localparam int unsigned SLEEP_BIT   = 0;
   localparam int unsigned STBY_BIT    = 1;
   localparam int unsigned OMODE_LSB   = 2;
   localparam int unsigned OMODE_W     = 3;
   localparam int unsigned SHF_LSB     = 5;
   localparam int unsigned SHF_W       = 2;
   localparam int unsigned SWF_LSB     = 7;
   localparam int unsigned SWF_W       = 4;

   localparam int unsigned CLAMP_LSB   = 0;
   localparam int unsigned CLAMP_W     = 5;
   localparam int unsigned FMUL_LSB    = 5;
   localparam int unsigned FMUL_W      = 2;
   localparam int unsigned FTIM_LSB    = 7;
   localparam int unsigned FTIM_W      = 2;
   localparam int unsigned LPWR_BIT    = 9;
   localparam int unsigned PINVA_BIT   = 10;
   localparam int unsigned PINVB_BIT   = 11;
endpackage

// File: rtl/ser_cfg_sync.sv
module ser_cfg_sync #(
   parameter int unsigned WIDTH   = 1,
   parameter int unsigned STAGES  = 2,
   parameter logic [WIDTH-1:0] RST_VAL = '0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);
   logic [STAGES-1:0][WIDTH-1:0] pipe;

   generate
      if (STAGES < 2) begin : g_bad_depth
         $error("ser_cfg_sync needs at least two stages");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pipe <= {STAGES{RST_VAL}};
      else        pipe <= {pipe[STAGES-2:0], d};
   end

   assign q = pipe[STAGES-1];
endmodule

// File: rtl/ser_cfg_shift.sv
module ser_cfg_shift #(
   parameter int unsigned FRAME_W   = 16,
   parameter bit          LSB_FIRST = 1'b1,
   localparam int unsigned CNT_MAX  = FRAME_W + 1,
   localparam int unsigned CNT_W    = $clog2(CNT_MAX + 1)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               sel_n,
   input  logic               sck,
   input  logic               sdi,
   output logic               commit,
   output logic [FRAME_W-1:0] frame,
   output logic [CNT_W-1:0]   bit_cnt
);
   logic sel_q, sck_q;
   logic sel_fall, sel_rise, sck_rise;
   logic [FRAME_W-1:0] shreg, shreg_nx;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sel_q <= 1'b1;
         sck_q <= 1'b0;
      end else begin
         sel_q <= sel_n;
         sck_q <= sck;
      end
   end

   assign sel_fall = sel_q & ~sel_n;
   assign sel_rise = ~sel_q & sel_n;
   assign sck_rise = ~sck_q & sck;

   generate
      if (LSB_FIRST) begin : g_lsb_first
         assign shreg_nx = {sdi, shreg[FRAME_W-1:1]};
      end else begin : g_msb_first
         assign shreg_nx = {shreg[FRAME_W-2:0], sdi};
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         shreg   <= '0;
         bit_cnt <= '0;
      end else if (sel_fall) begin
         shreg   <= '0;
         bit_cnt <= '0;
      end else if (!sel_n && sck_rise) begin
         shreg <= shreg_nx;
         if (bit_cnt != CNT_W'(CNT_MAX)) bit_cnt <= bit_cnt + 1'b1;
      end
   end

   assign commit = sel_rise && (bit_cnt == CNT_W'(FRAME_W));
   assign frame  = shreg;
endmodule

// File: rtl/ser_cfg_regs.sv
module ser_cfg_regs #(
   parameter int unsigned ADDR_W    = 3,
   parameter int unsigned PAYLOAD_W = 13,
   parameter int unsigned NUM_REGS  = 4,
   parameter int unsigned SRST_REG  = 2,
   parameter int unsigned SRST_BIT  = 12,
   parameter logic [NUM_REGS-1:0][PAYLOAD_W-1:0] DEFS = '0
) (
   input  logic                               clk,
   input  logic                               rst_n,
   input  logic                               wr,
   input  logic [ADDR_W-1:0]                  addr,
   input  logic [PAYLOAD_W-1:0]               data,
   output logic [NUM_REGS-1:0][PAYLOAD_W-1:0] regs,
   output logic                               srst_n
);
   assign srst_n = regs[SRST_REG][SRST_BIT];

   generate
      for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
         logic [PAYLOAD_W-1:0] word;
         logic                 hit;
         assign hit = wr && (addr == ADDR_W'(i));
         if (i == SRST_REG) begin : g_ctl
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n)   word <= DEFS[i];
               else if (hit) word <= data;
            end
         end else begin : g_held
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n)       word <= DEFS[i];
               else if (!srst_n) word <= DEFS[i];
               else if (hit)     word <= data;
            end
         end
         assign regs[i] = word;
      end
   endgenerate
endmodule

// File: rtl/ser_cfg_bank.sv
module ser_cfg_bank
   import ser_cfg_pkg::*;
#(
   parameter int unsigned FRAME_W     = 16,
   parameter int unsigned ADDR_W      = 3,
   parameter int unsigned SYNC_STAGES = 2,
   parameter bit          LSB_FIRST   = 1'b1,
   parameter logic [12:0] DEF_GAIN    = 13'h0040,
   parameter logic [12:0] DEF_MODE    = 13'h0000,
   parameter logic [12:0] DEF_ANALOG  = 13'h1010,
   parameter logic [12:0] DEF_AUX     = 13'h0000
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        ser_sel_n,
   input  logic        ser_clk,
   input  logic        ser_dat,
   output logic [9:0]  gain_code,
   output logic        in_sel_a,
   output logic        in_sel_b,
   output logic        sleep_en,
   output logic        stby_en,
   output logic [2:0]  out_mode,
   output logic [1:0]  sh_filt,
   output logic [3:0]  sw_filt,
   output logic [4:0]  clamp_lvl,
   output logic [1:0]  fast_mult,
   output logic [1:0]  fast_time,
   output logic        low_pwr,
   output logic        pol_inv_a,
   output logic        pol_inv_b,
   output logic        soft_rst_n,
   output logic [12:0] aux_cfg
);
   localparam int unsigned PAYLOAD_W = FRAME_W - ADDR_W;
   localparam int unsigned CNT_W     = $clog2(FRAME_W + 2);
   localparam logic [USER_REGS-1:0][PAYLOAD_W-1:0] DEFS =
      {PAYLOAD_W'(DEF_AUX), PAYLOAD_W'(DEF_ANALOG),
       PAYLOAD_W'(DEF_MODE), PAYLOAD_W'(DEF_GAIN)};

   generate
      if (PAYLOAD_W < MAP_BITS) begin : g_bad_payload
         $error("payload narrower than the field map");
      end
      if ((1 << ADDR_W) < USER_REGS) begin : g_bad_addr
         $error("address field too narrow for the user registers");
      end
   endgenerate

   logic [2:0]                                s_vec;
   logic                                      sel_s, sck_s, sdi_s;
   logic                                      commit;
   logic [FRAME_W-1:0]                        frame;
   logic [CNT_W-1:0]                          bit_cnt;
   logic [ADDR_W-1:0]                         frame_addr;
   logic [PAYLOAD_W-1:0]                      frame_data;
   logic [USER_REGS-1:0][PAYLOAD_W-1:0]       regs;
   logic                                      srst_n;

   ser_cfg_sync #(.WIDTH(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)) u_sync (
      .clk(clk), .rst_n(rst_n),
      .d({ser_sel_n, ser_clk, ser_dat}), .q(s_vec)
   );
   assign sel_s = s_vec[2];
   assign sck_s = s_vec[1];
   assign sdi_s = s_vec[0];

   ser_cfg_shift #(.FRAME_W(FRAME_W), .LSB_FIRST(LSB_FIRST)) u_shift (
      .clk(clk), .rst_n(rst_n), .sel_n(sel_s), .sck(sck_s), .sdi(sdi_s),
      .commit(commit), .frame(frame), .bit_cnt(bit_cnt)
   );

   assign frame_addr = frame[FRAME_W-1 -: ADDR_W];
   assign frame_data = frame[PAYLOAD_W-1:0];

   ser_cfg_regs #(
      .ADDR_W(ADDR_W), .PAYLOAD_W(PAYLOAD_W), .NUM_REGS(USER_REGS),
      .SRST_REG(REG_ANALOG), .SRST_BIT(SRST_BIT), .DEFS(DEFS)
   ) u_regs (
      .clk(clk), .rst_n(rst_n), .wr(commit), .addr(frame_addr),
      .data(frame_data), .regs(regs), .srst_n(srst_n)
   );

   assign gain_code  = regs[REG_GAIN][GAIN_LSB +: GAIN_W];
   assign in_sel_a   = regs[REG_GAIN][SELA_BIT];
   assign in_sel_b   = regs[REG_GAIN][SELB_BIT];
   assign sleep_en   = regs[REG_MODE][SLEEP_BIT];
   assign stby_en    = regs[REG_MODE][STBY_BIT];
   assign out_mode   = regs[REG_MODE][OMODE_LSB +: OMODE_W];
   assign sh_filt    = regs[REG_MODE][SHF_LSB +: SHF_W];
   assign sw_filt    = regs[REG_MODE][SWF_LSB +: SWF_W];
   assign clamp_lvl  = regs[REG_ANALOG][CLAMP_LSB +: CLAMP_W];
   assign fast_mult  = regs[REG_ANALOG][FMUL_LSB +: FMUL_W];
   assign fast_time  = regs[REG_ANALOG][FTIM_LSB +: FTIM_W];
   assign low_pwr    = regs[REG_ANALOG][LPWR_BIT];
   assign pol_inv_a  = regs[REG_ANALOG][PINVA_BIT];
   assign pol_inv_b  = regs[REG_ANALOG][PINVB_BIT];
   assign soft_rst_n = srst_n;
   assign aux_cfg    = regs[REG_AUX][12:0];
endmodule

// File: rtl/ser_cfg_chk.sv
module ser_cfg_chk #(
   parameter int unsigned FRAME_W   = 16,
   parameter int unsigned ADDR_W    = 3,
   parameter int unsigned PAYLOAD_W = 13,
   parameter int unsigned CNT_W     = 5,
   parameter int unsigned NREG      = 4,
   parameter logic [NREG-1:0][PAYLOAD_W-1:0] DEFS = '0
) (
   input logic                           clk,
   input logic                           rst_n,
   input logic                           commit,
   input logic [ADDR_W-1:0]              addr,
   input logic [CNT_W-1:0]               bit_cnt,
   input logic                           srst_n,
   input logic [NREG-1:0][PAYLOAD_W-1:0] regs
);
   assert_single_commit_R3: assert property (@(posedge clk) disable iff (!rst_n)
      commit |=> !commit);

   assert_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (!commit && srst_n) |=> $stable(regs));

   assert_protect_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (commit && (addr >= ADDR_W'(NREG)) && srst_n) |=> $stable(regs));

   assert_srst_defaults_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !srst_n |=> (regs[0] == DEFS[0] && regs[1] == DEFS[1] && regs[3] == DEFS[3]));

   assert_cnt_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
      bit_cnt <= CNT_W'(FRAME_W + 1));
endmodule

bind ser_cfg_bank ser_cfg_chk #(
   .FRAME_W(FRAME_W), .ADDR_W(ADDR_W), .PAYLOAD_W(PAYLOAD_W),
   .CNT_W(CNT_W), .NREG(ser_cfg_pkg::USER_REGS), .DEFS(DEFS)
) u_chk (
   .clk(clk), .rst_n(rst_n), .commit(commit), .addr(frame_addr),
   .bit_cnt(bit_cnt), .srst_n(srst_n), .regs(regs)
);

// File: tb/sim_ser_cfg_bank.sv
module sim_ser_cfg_bank;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic ser_sel_n = 1'b1, ser_clk = 1'b0, ser_dat = 1'b0;
   logic [9:0] gain_code; logic in_sel_a, in_sel_b, sleep_en, stby_en;
   logic [2:0] out_mode; logic [1:0] sh_filt; logic [3:0] sw_filt;
   logic [4:0] clamp_lvl; logic [1:0] fast_mult, fast_time;
   logic low_pwr, pol_inv_a, pol_inv_b, soft_rst_n; logic [12:0] aux_cfg;

   int checks = 0, failures = 0;
   bit done = 1'b0;
   logic [12:0] m [4];
   localparam logic [12:0] D0 = 13'h0040, D1 = 13'h0000, D2 = 13'h1010, D3 = 13'h0000;

   always #4 clk = ~clk;

   ser_cfg_bank u0 (.*);

   // {clock count, frame}
   localparam int NV = 13;
   localparam logic [23:0] VEC [NV] = '{
      {8'd16, 16'h0B5A}, {8'd16, 16'h3FFF}, {8'd16, 16'h5ABC}, {8'd16, 16'h6777},
      {8'd15, 16'h0123}, {8'd17, 16'h2000}, {8'd16, 16'hB234}, {8'd16, 16'hFFFF},
      {8'd16, 16'h4ABC}, {8'd16, 16'h03FF}, {8'd16, 16'h5015}, {8'd16, 16'h0C01},
      {8'd1,  16'h6555}};

   function automatic string vtag(int k);
      case (k)
         0: return "R7";  1: return "R8";  2: return "R9";  3: return "R11";
         4: return "R4";  5: return "R5";  6: return "R6";  7: return "R6";
         8: return "R10"; 9: return "R10"; 10: return "R10"; 11: return "R2";
         default: return "R4";
      endcase
   endfunction

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic compare_all(input string tag);
      check({tag, " R7 gain"}, 32'(gain_code), 32'(m[0][9:0]));
      check({tag, " R7 sel"}, 32'({in_sel_b, in_sel_a}), 32'(m[0][11:10]));
      check({tag, " R8 mode"}, 32'({sw_filt, sh_filt, out_mode, stby_en, sleep_en}), 32'(m[1][10:0]));
      check({tag, " R9 analog"}, 32'({soft_rst_n, pol_inv_b, pol_inv_a, low_pwr,
            fast_time, fast_mult, clamp_lvl}), 32'(m[2]));
      check({tag, " R11 aux"}, 32'(aux_cfg), 32'(m[3]));
   endtask

   task automatic model(input logic [15:0] w, input int n);
      if (n == 16 && w[15:13] < 3'd4) begin
         if (w[15:13] == 3'd2)  m[2] = w[12:0];
         else if (m[2][12])     m[w[15:13]] = w[12:0];
      end
      if (!m[2][12]) begin m[0] = D0; m[1] = D1; m[3] = D3; end
   endtask

   task automatic pulse(input logic b);
      ser_dat = b;
      repeat (8) @(negedge clk);
      ser_clk = 1'b1;
      repeat (8) @(negedge clk);
      ser_clk = 1'b0;
   endtask

   task automatic shift_bits(input logic [15:0] w, input int n);
      ser_sel_n = 1'b0;
      repeat (4) @(negedge clk);
      for (int i = 0; i < n; i++) pulse(i < 16 ? w[i] : 1'b0);
      repeat (6) @(negedge clk);
   endtask

   task automatic end_frame();
      ser_sel_n = 1'b1;
      repeat (12) @(negedge clk);
   endtask

   task automatic send(input logic [15:0] w, input int n);
      shift_bits(w, n);
      end_frame();
      model(w, n);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         failures++;
         $display("FAIL watchdog expired, all requirements actual=hung expected=done");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      m[0] = D0; m[1] = D1; m[2] = D2; m[3] = D3;
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      repeat (5) @(negedge clk);
      compare_all("R1 reset");

      for (int k = 0; k < NV; k++) begin
         send(VEC[k][15:0], int'(VEC[k][23:16]));
         compare_all(vtag(k));
      end

      // R3: complete frame held with select low must not commit
      shift_bits(16'h0155, 16);
      check("R3 before select rise", 32'(gain_code), 32'(m[0][9:0]));
      end_frame();
      model(16'h0155, 16);
      check("R3 after select rise", 32'(gain_code), 32'h155);

      // R12: stray clocks while deselected
      for (int j = 0; j < 5; j++) pulse(1'b1);
      repeat (4) @(negedge clk);
      send(16'h2003, 16);
      check("R12 sleep", 32'(sleep_en), 32'd1);
      check("R12 standby", 32'(stby_en), 32'd1);
      compare_all("R12");

      // R2: bit 9 lands in gain MSB
      send(16'h0200, 16);
      check("R2 gain msb", 32'(gain_code), 32'h200);

      // R10: commit to reg0 while soft reset low loses to the defaults
      send(16'h4000, 16);
      send(16'h0321, 16);
      check("R10 held default", 32'(gain_code), 32'(D0[9:0]));
      send(16'h5000, 16);
      send(16'h0321, 16);
      check("R10 released write", 32'(gain_code), 32'h321);

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule